// File: doc/BRIEF.md
# Interval Timer with Sticky Underflow Flag

This block is an 8-bit interval timer that counts down. A bus write loads the counter and chooses a clock prescaler of 1, 8, 64 or 1024 at the same moment. While the underflow flag is clear, the counter steps down once per prescaler period. When the counter rolls over from 0x00 to 0xFF, the flag goes high. From then on the prescaler is bypassed and the counter steps down on every clock, rolling over freely.

A read or a write of the counter clears the flag. There is one exception: an access made in the very clock in which the rollover happens leaves the flag set. This holds on every later rollover as well, including when the flag is already high.

A status read returns the flag without changing it. Two debug pulses mark a counter read, or a counter write, that falls on a rollover clock.

Top module: `itmr_top`

## Requirements
- R1: While the flag is clear, the counter decrements once every N clocks. N is 1, 8, 64 or 1024 for `wr_div_sel` = 0, 1, 2 or 3. A write loads `wr_data` and restarts the prescaler phase, so the first step comes N clocks after the write edge.
- R2: A clock edge at which the counter passes from 0x00 to 0xFF sets `irq_flag`. The flag stays set if it was already set.
- R3: While `irq_flag` is set, the counter decrements on every clock whatever divider is selected, and it wraps through 0xFF.
- R4: A counter read (`rd_cnt_en`) or a counter write (`wr_en`) clears `irq_flag` at the next edge, provided that clock is not a rollover clock.
- R5: A counter read or write in a rollover clock leaves `irq_flag` set after the edge. This also applies on later rollovers while the flag is already set.
- R6: With `rd_stat_en` high and `rd_cnt_en` low, `rd_data` is {flag, 7'b0}. A status read never changes the flag.
- R7: With `rd_cnt_en` high, `rd_data` shows the current counter value in the same cycle. A counter read takes priority over a status read. With neither read, `rd_data` is 0.
- R8: `dbg_rd_wrap` is high exactly when `rd_cnt_en` is high in a rollover clock.
- R9: `dbg_wr_wrap` is high exactly when `wr_en` is high in a rollover clock.
- R10: Reset clears the counter, the prescaler phase and the flag, and selects the divide-by-1024 prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Counter write strobe |
| wr_data | input | 8 | Value loaded into the counter |
| wr_div_sel | input | 2 | Prescaler select, sampled on a write |
| rd_cnt_en | input | 1 | Counter read strobe |
| rd_stat_en | input | 1 | Status read strobe |
| rd_data | output | 8 | Read data (counter or status) |
| irq_flag | output | 1 | Sticky underflow flag |
| dbg_rd_wrap | output | 1 | Counter read fell on a rollover clock |
| dbg_wr_wrap | output | 1 | Counter write fell on a rollover clock |

## Verification
The assertions assume that the strobes and the write data are known, 0 or 1, from the first edge after reset. They also assume that a strobe held across an edge counts as one access for that clock. Every 2-bit select value is legal, so no input constraint is needed there. The bench changes inputs only on falling edges and holds all strobes low during reset, which keeps every `$past` sample defined. Rollover-clock accesses are aimed at by counting edges from a known write, so each debug pulse and each flag exception is hit on its exact clock.

// File: rtl/itmr_pkg.sv
package itmr_pkg;

    localparam int PHASE_W = 10;

    typedef enum logic [1:0] {
        DIV_1    = 2'd0,
        DIV_8    = 2'd1,
        DIV_64   = 2'd2,
        DIV_1024 = 2'd3
    } div_sel_e;

    // last phase value of a prescaler period
    function automatic logic [PHASE_W-1:0] div_terminal(div_sel_e sel);
        logic [PHASE_W-1:0] t;
        case (sel)
            DIV_1:   t = PHASE_W'(0);
            DIV_8:   t = PHASE_W'(7);
            DIV_64:  t = PHASE_W'(63);
            default: t = PHASE_W'(1023);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler
    import itmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     restart_i,
    input  div_sel_e sel_i,
    input  logic     bypass_i,
    output logic     tick_o
);

    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        div_sel_e           sel;
    } presc_t;

    presc_t             st_d, st_q;
    logic [PHASE_W-1:0] term;

    always_comb begin
        st_d   = st_q;
        term   = div_terminal(st_q.sel);
        tick_o = bypass_i || (st_q.phase == term);
        if (restart_i) begin
            st_d.phase = '0;
            st_d.sel   = sel_i;
        end else if (st_q.phase == term) begin
            st_d.phase = '0;
        end else begin
            st_d.phase = st_q.phase + PHASE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= '0;
            st_q.sel   <= DIV_1024;
        end else begin
            st_q <= st_d;
        end
    end

    AST_PHASE_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase <= div_terminal(st_q.sel)) else $error("phase beyond period"); // R1
    AST_RESTART_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (st_q.phase == '0)) else $error("restart missed"); // R1

endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             flag_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        wrap_o = tick_i && (st_q.cnt == '0);
        if (load_i) begin
            st_d.cnt = load_val_i;
        end else if (tick_i) begin
            st_d.cnt = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o = st_q.cnt;

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (cnt_o == $past(load_val_i))) else $error("load lost"); // R1
    AST_FAST_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_i && !load_i) |=> (cnt_o == $past(cnt_o) - CNT_W'(1))) else $error("bypass rate"); // R3

endmodule

// File: rtl/itmr_flag.sv
module itmr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic wrap_i,
    input  logic access_i,
    output logic flag_o
);

    typedef struct packed {
        logic flag;
    } flag_t;

    flag_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wrap_i)        st_d.flag = 1'b1;
        else if (access_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;

    AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> flag_o) else $error("wrap did not set flag"); // R2
    AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (access_i && !wrap_i) |=> !flag_o) else $error("access kept flag"); // R4
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!access_i && !wrap_i) |=> $stable(flag_o)) else $error("flag moved"); // R6

endmodule

// File: rtl/itmr_top.sv
module itmr_top
    import itmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       wr_div_sel,
    input  logic             rd_cnt_en,
    input  logic             rd_stat_en,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq_flag,
    output logic             dbg_rd_wrap,
    output logic             dbg_wr_wrap
);

    logic             tick;
    logic             wrap;
    logic             flag;
    logic [CNT_W-1:0] cnt;

    itmr_prescaler i_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (wr_en),
        .sel_i     (div_sel_e'(wr_div_sel)),
        .bypass_i  (flag),
        .tick_o    (tick)
    );

    itmr_counter #(.CNT_W(CNT_W)) i_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (wr_en),
        .load_val_i (wr_data),
        .flag_i     (flag),
        .cnt_o      (cnt),
        .wrap_o     (wrap)
    );

    itmr_flag i_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap_i   (wrap),
        .access_i (wr_en || rd_cnt_en),
        .flag_o   (flag)
    );

    always_comb begin
        if (rd_cnt_en)       rd_data = cnt;
        else if (rd_stat_en) rd_data = {flag, {(CNT_W-1){1'b0}}};
        else                 rd_data = '0;
    end

    assign irq_flag    = flag;
    assign dbg_rd_wrap = rd_cnt_en && wrap;
    assign dbg_wr_wrap = wr_en && wrap;

    AST_STATUS_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_en && !rd_cnt_en) |-> (rd_data[CNT_W-2:0] == '0)) else $error("status bits"); // R6
    AST_RD_PULSE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_rd_wrap |-> (rd_cnt_en && rd_data == '0)) else $error("read pulse"); // R8
    AST_WR_PULSE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_wr_wrap |=> irq_flag) else $error("write at wrap cleared flag"); // R9
    AST_RD_PULSE_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_rd_wrap |=> irq_flag) else $error("read at wrap cleared flag"); // R5

endmodule

// File: tb/test_itmr_top.sv
module test_itmr_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] wr_div_sel = '0;
    logic       rd_cnt_en = 1'b0;
    logic       rd_stat_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq_flag;
    logic       dbg_rd_wrap;
    logic       dbg_wr_wrap;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    itmr_top i_itmr_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .wr_div_sel (wr_div_sel),
        .rd_cnt_en  (rd_cnt_en),
        .rd_stat_en (rd_stat_en),
        .rd_data    (rd_data),
        .irq_flag   (irq_flag),
        .dbg_rd_wrap(dbg_rd_wrap),
        .dbg_wr_wrap(dbg_wr_wrap)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [7:0]  val;
        logic [11:0] wait_n;
        logic [7:0]  exp;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{2'd0, 8'd50,  12'd10,   8'd40},
        '{2'd1, 8'd20,  12'd16,   8'd18},
        '{2'd2, 8'd5,   12'd130,  8'd3},
        '{2'd3, 8'd2,   12'd1023, 8'd2},
        '{2'd3, 8'd2,   12'd1024, 8'd1},
        '{2'd1, 8'd3,   12'd7,    8'd3},
        '{2'd0, 8'd255, 12'd254,  8'd1}
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        wr_en = 1'b0; rd_cnt_en = 1'b0; rd_stat_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(logic [7:0] v, logic [1:0] s, logic exp_pulse, string req);
        wr_en = 1'b1; wr_data = v; wr_div_sel = s;
        #1 check(req, {7'b0, dbg_wr_wrap}, {7'b0, exp_pulse});
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_cnt(logic [7:0] exp, logic exp_pulse, string req);
        rd_cnt_en = 1'b1;
        #1;
        check(req, rd_data, exp);
        check("R8", {7'b0, dbg_rd_wrap}, {7'b0, exp_pulse});
        @(negedge clk);
        rd_cnt_en = 1'b0;
    endtask

    task automatic rd_stat(logic [7:0] exp);
        rd_stat_en = 1'b1;
        #1 check("R6 status", rd_data, exp);
        @(negedge clk);
        rd_stat_en = 1'b0;
    endtask

    task automatic chk_flag(string req, logic exp);
        check(req, {7'b0, irq_flag}, {7'b0, exp});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        // R10 reset state and default divider
        @(negedge clk);
        do_reset();
        chk_flag("R10 flag", 1'b0);
        rd_stat_en = 1'b1;
        #1 check("R10 status", rd_data, 8'h00);
        rd_stat_en = 1'b0; rd_cnt_en = 1'b1;
        #1 check("R10 count", rd_data, 8'h00);
        rd_cnt_en = 1'b0;
        #1 check("R7 idle data", rd_data, 8'h00);
        idle(1023);
        chk_flag("R10 div1024 no wrap yet", 1'b0);
        idle(1);
        chk_flag("R2 wrap sets", 1'b1);
        rd_stat(8'h80);
        chk_flag("R6 status keeps flag", 1'b1);
        rd_cnt(8'hFE, 1'b0, "R3 fast after wrap");
        chk_flag("R4 read clears", 1'b0);

        // R1 table of divider cases
        foreach (VECS[i]) begin
            wr(VECS[i].val, VECS[i].sel, 1'b0, "R9 no pulse");
            idle(int'(VECS[i].wait_n));
            rd_cnt(VECS[i].exp, 1'b0, "R1 divided count");
            chk_flag("R1 flag clear", 1'b0);
        end

        // R3 bypass after wrap
        do_reset();
        wr(8'd3, 2'd2, 1'b0, "R9");
        idle(255);
        chk_flag("R2 before wrap", 1'b0);
        idle(1);
        chk_flag("R2 at wrap", 1'b1);
        idle(5);
        rd_cnt(8'hFA, 1'b0, "R3 1T rate");
        chk_flag("R4 read clears", 1'b0);

        // R5 read at wrap
        wr(8'd0, 2'd0, 1'b0, "R9");
        rd_cnt(8'h00, 1'b1, "R5 read at wrap data");
        chk_flag("R5 read at wrap keeps", 1'b1);
        rd_cnt(8'hFF, 1'b0, "R7 read after wrap");
        chk_flag("R4 later read clears", 1'b0);

        // R9 write at wrap
        wr(8'd1, 2'd0, 1'b0, "R9");
        idle(1);
        wr(8'h40, 2'd1, 1'b1, "R9 write at wrap pulse");
        chk_flag("R5 write at wrap keeps", 1'b1);
        rd_cnt(8'h40, 1'b0, "R7 loaded value");
        chk_flag("R4 read clears", 1'b0);
        idle(6);
        rd_cnt(8'h3F, 1'b0, "R1 phase restart");
        rd_cnt(8'h3E, 1'b0, "R1 step after 8");

        // R5 later wraps with flag already set
        wr(8'd0, 2'd0, 1'b0, "R9");
        idle(1);
        chk_flag("R2 set", 1'b1);
        idle(255);
        rd_cnt(8'h00, 1'b1, "R5 read on later wrap");
        chk_flag("R5 flag stays", 1'b1);
        idle(255);
        wr(8'h10, 2'd0, 1'b1, "R9 write on later wrap");
        chk_flag("R5 flag stays after write", 1'b1);
        rd_stat(8'h80);
        chk_flag("R6 status no clear", 1'b1);
        wr(8'h20, 2'd0, 1'b0, "R9");
        chk_flag("R4 write clears", 1'b0);
        rd_stat(8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule